// File: doc/BRIEF.md
# AGC Gain Update Timing Controller

This block paces the gain changes of a receive automatic gain control loop. It steps through three phases without end. First comes a programmable update interval. Then comes a programmable settling delay. Last comes a fixed delay of five clock cycles, after which the update interval starts again. The level detectors outside the block send it attack requests, which ask for less gain, and recovery requests, which ask for more gain. The block turns these into single-cycle gain-decrement and gain-increment strobes at the allowed moments, and it reports the current phase.

An attack is taken at once during the update interval, but only when fast attack is enabled. A recovery is held back until the interval ends, so that gain increases line up with the interval boundary. Each accepted attack starts a hold-off counter loaded with the settling length. While that counter runs, no further attack is accepted and the interval cannot hand over to the settling phase. An attack close to the end of the interval therefore stretches the interval and moves the recovery that follows it. Setting the fast-recovery flag replaces the normal interval length with a separate, shorter low-under-range length.

Top module: `agc_gain_sequencer`

## Requirements
- R1: `phase` encodes 0 as the update interval, 1 as settling and 2 as the fixed delay. Phases always follow the order 0, 1, 2, 0.
- R2: The fixed-delay phase (`phase`=2) lasts exactly 5 cycles.
- R3: The update interval lasts max(`upd_len`,1) cycles and settling lasts max(`settle_len`,1) cycles. Each length is sampled when its phase is entered, and later changes do not affect the running phase.
- R4: When `fast_recov_en` is high at the start of an update interval, that interval uses max(`luri_len`,1) in place of `upd_len`.
- R5: An attack request is accepted only while `phase`=0 with `fast_attack_en` high. Each accepted request produces a one-cycle `gain_dec` pulse in the following cycle. Requests in other phases, or with fast attack disabled, produce no pulse.
- R6: After an accepted attack, attack requests in the next max(`settle_len`,1) cycles are ignored.
- R7: An attack accepted in cycle a of an interval of length L, with hold-off S, leaves the interval length at L if L-1-a > S. Otherwise the interval ends in cycle a+S+1, so it lasts a+S+2 cycles.
- R8: A recovery request seen in any cycle of the update interval yields exactly one `gain_inc` pulse, in the first settling cycle. Requests made outside the update interval are ignored.
- R9: If an attack is accepted in the cycle where the interval count expires, any pending recovery is dropped and no `gain_inc` follows.
- R10: Synchronous reset `rst` puts the block at the start of an update interval with the hold-off counter cleared and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| attack_req | input | 1 | Request to lower the gain |
| recover_req | input | 1 | Request to raise the gain |
| fast_attack_en | input | 1 | Allows attacks inside the update interval |
| fast_recov_en | input | 1 | Selects `luri_len` as the interval length |
| upd_len | input | 16 | Normal update interval length in cycles |
| luri_len | input | 16 | Low-under-range interval length in cycles |
| settle_len | input | 16 | Settling delay and hold-off length in cycles |
| gain_dec | output | 1 | One-cycle gain-decrement strobe |
| gain_inc | output | 1 | One-cycle gain-increment strobe |
| phase | output | 2 | Current phase (0 interval, 1 settling, 2 fixed delay) |

## Verification
The bench places attacks on both sides of the hold-off window: exactly S cycles before expiry, S+1 cycles before expiry, and on the expiry cycle itself. An off-by-one in the stall logic or in the hold-off length shows up as an interval that is one cycle too long or too short, or as a missing stall. A second attack inside the hold-off, and another one just after it, show whether the counter blocks for too long or not long enough. The bench also sends a recovery together with an attack on the expiry cycle, which a design with the wrong priority would answer with a stray `gain_inc`. Further cases cover zero lengths, a length change made mid-phase (which would be adopted too early), requests made outside the interval (which would leak through), and a reset during hold-off (which would leave the next attack blocked).

// File: rtl/agc_seq_pkg.sv
package agc_seq_pkg;

    typedef enum logic [1:0] {
        PH_UPD    = 2'd0,
        PH_SETTLE = 2'd1,
        PH_FIX    = 2'd2
    } phase_e;

endpackage

// File: rtl/agc_holdoff.sv
module agc_holdoff #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] settle_len,
    output logic             busy
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;
    logic [LEN_W-1:0] load_val;

    // a zero setting still blocks for one cycle
    always_comb begin
        load_val = (settle_len == '0) ? LEN_W'(1) : settle_len;
        st_d     = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    // R6: the top must never reload while the counter is still running
    a_r6_load_only_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    // R6: after a load the counter stays busy on the next cycle
    a_r6_busy_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> busy);

endmodule

// File: rtl/agc_phase_timer.sv
module agc_phase_timer
    import agc_seq_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FIX_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] upd_len,
    input  logic [LEN_W-1:0] luri_len,
    input  logic [LEN_W-1:0] settle_len,
    input  logic             fast_recov_en,
    input  logic             hold_busy,
    input  logic             attack_acc,
    output phase_e           phase,
    output logic             at_expiry,
    output logic             leave_upd
);

    localparam logic [LEN_W-1:0] FIX_LOAD = LEN_W'(FIX_CYCLES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [LEN_W-1:0] upd_sel;
    logic [LEN_W-1:0] upd_load;
    logic [LEN_W-1:0] set_load;

    // count down from length-1; zero lengths act as one cycle
    always_comb begin
        upd_sel  = fast_recov_en ? luri_len : upd_len;
        upd_load = (upd_sel == '0) ? '0 : upd_sel - LEN_W'(1);
        set_load = (settle_len == '0) ? '0 : settle_len - LEN_W'(1);
    end

    always_comb begin
        at_expiry = (st_q.ph == PH_UPD) && (st_q.cnt == '0);
        leave_upd = at_expiry && !hold_busy && !attack_acc;
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ph  = PH_UPD;
            st_d.cnt = upd_load;
        end else begin
            unique case (st_q.ph)
                PH_UPD: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - LEN_W'(1);
                    end else if (leave_upd) begin
                        st_d.ph  = PH_SETTLE;
                        st_d.cnt = set_load;
                    end
                end
                PH_SETTLE: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - LEN_W'(1);
                    end else begin
                        st_d.ph  = PH_FIX;
                        st_d.cnt = FIX_LOAD;
                    end
                end
                PH_FIX: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - LEN_W'(1);
                    end else begin
                        st_d.ph  = PH_UPD;
                        st_d.cnt = upd_load;
                    end
                end
                default: begin
                    st_d.ph  = PH_UPD;
                    st_d.cnt = upd_load;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase = st_q.ph;

    // R1: a phase change always goes to the next phase in the ring
    a_r1_phase_order: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != $past(st_q.ph)) |->
            ((($past(st_q.ph) == PH_UPD)    && (st_q.ph == PH_SETTLE)) ||
             (($past(st_q.ph) == PH_SETTLE) && (st_q.ph == PH_FIX))    ||
             (($past(st_q.ph) == PH_FIX)    && (st_q.ph == PH_UPD))));

    // R7: a running hold-off keeps the block in the update interval
    a_r7_hold_stalls: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_UPD && hold_busy) |=> (st_q.ph == PH_UPD));

    // R2: the fixed delay never counts beyond its length
    a_r2_fix_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_FIX) |-> (st_q.cnt < LEN_W'(FIX_CYCLES)));

endmodule

// File: rtl/agc_strobe_gen.sv
module agc_strobe_gen (
    input  logic clk,
    input  logic rst,
    input  logic in_upd,
    input  logic at_expiry,
    input  logic attack_acc,
    input  logic leave_upd,
    input  logic recover_req,
    output logic gain_dec,
    output logic gain_inc
);

    typedef struct packed {
        logic rec_pend;
        logic dec;
        logic inc;
    } strb_t;

    strb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.dec = attack_acc;
            st_d.inc = leave_upd && (st_q.rec_pend || recover_req);
            if (leave_upd) begin
                st_d.rec_pend = 1'b0;
            end else if (at_expiry && attack_acc) begin
                // attack wins at the boundary: discard pending recovery
                st_d.rec_pend = 1'b0;
            end else if (in_upd && recover_req) begin
                st_d.rec_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gain_dec = st_q.dec;
    assign gain_inc = st_q.inc;

    // R9: an attack taken at expiry leaves nothing pending
    a_r9_drop_on_attack: assert property (@(posedge clk) disable iff (rst)
        (at_expiry && attack_acc) |=> !st_q.rec_pend);

endmodule

// File: rtl/agc_gain_sequencer.sv
module agc_gain_sequencer
    import agc_seq_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FIX_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             attack_req,
    input  logic             recover_req,
    input  logic             fast_attack_en,
    input  logic             fast_recov_en,
    input  logic [LEN_W-1:0] upd_len,
    input  logic [LEN_W-1:0] luri_len,
    input  logic [LEN_W-1:0] settle_len,
    output logic             gain_dec,
    output logic             gain_inc,
    output logic [1:0]       phase
);

    phase_e ph;
    logic   hold_busy;
    logic   attack_acc;
    logic   at_expiry;
    logic   leave_upd;
    logic   in_upd;

    always_comb begin
        in_upd     = (ph == PH_UPD);
        attack_acc = in_upd && attack_req && fast_attack_en && !hold_busy && !rst;
    end

    agc_holdoff #(
        .LEN_W (LEN_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (attack_acc),
        .settle_len (settle_len),
        .busy       (hold_busy)
    );

    agc_phase_timer #(
        .LEN_W      (LEN_W),
        .FIX_CYCLES (FIX_CYCLES)
    ) u_tmr (
        .clk           (clk),
        .rst           (rst),
        .upd_len       (upd_len),
        .luri_len      (luri_len),
        .settle_len    (settle_len),
        .fast_recov_en (fast_recov_en),
        .hold_busy     (hold_busy),
        .attack_acc    (attack_acc),
        .phase         (ph),
        .at_expiry     (at_expiry),
        .leave_upd     (leave_upd)
    );

    agc_strobe_gen u_strb (
        .clk         (clk),
        .rst         (rst),
        .in_upd      (in_upd),
        .at_expiry   (at_expiry),
        .attack_acc  (attack_acc),
        .leave_upd   (leave_upd),
        .recover_req (recover_req),
        .gain_dec    (gain_dec),
        .gain_inc    (gain_inc)
    );

    assign phase = ph;

    // R5: a decrement strobe follows an allowed request in the interval
    a_r5_dec_origin: assert property (@(posedge clk) disable iff (rst)
        gain_dec |-> $past(fast_attack_en && attack_req && ph == PH_UPD));

    // R6: two decrements are never back to back
    a_r6_dec_spacing: assert property (@(posedge clk) disable iff (rst)
        gain_dec |=> !gain_dec);

    // R8: an increment appears only on entry to settling
    a_r8_inc_at_boundary: assert property (@(posedge clk) disable iff (rst)
        gain_inc |-> (ph == PH_SETTLE && $past(ph) == PH_UPD));

    // R9: the two strobes never coincide
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gain_dec && gain_inc));

endmodule

// File: tb/sim_agc_gain_sequencer.sv
module sim_agc_gain_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        attack_req = 1'b0;
    logic        recover_req = 1'b0;
    logic        fast_attack_en = 1'b0;
    logic        fast_recov_en = 1'b0;
    logic [15:0] upd_len = 16'd10;
    logic [15:0] luri_len = 16'd0;
    logic [15:0] settle_len = 16'd3;
    logic        gain_dec;
    logic        gain_inc;
    logic [1:0]  phase;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    agc_gain_sequencer u0 (
        .clk            (clk),
        .rst            (rst),
        .attack_req     (attack_req),
        .recover_req    (recover_req),
        .fast_attack_en (fast_attack_en),
        .fast_recov_en  (fast_recov_en),
        .upd_len        (upd_len),
        .luri_len       (luri_len),
        .settle_len     (settle_len),
        .gain_dec       (gain_dec),
        .gain_inc       (gain_inc),
        .phase          (phase)
    );

    // upd, luri, set, frec, fatt, attack a, attack a2, recovery r,
    // expected interval, expected settling, expected decs, expected incs
    typedef struct packed {
        int upd; int luri; int set; int frec; int fatt;
        int a; int a2; int r;
        int eupd; int eset; int edec; int einc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{10, 0, 3, 0, 1, -1, -1, -1, 10, 3, 0, 0},
        '{10, 0, 3, 0, 1, -1, -1,  4, 10, 3, 0, 1},
        '{ 0, 0, 0, 0, 1, -1, -1, -1,  1, 1, 0, 0},
        '{10, 4, 3, 1, 1, -1, -1,  1,  4, 3, 0, 1},
        '{10, 0, 3, 0, 1,  2, -1,  5, 10, 3, 1, 1},
        '{10, 0, 3, 0, 1,  6, -1, -1, 11, 3, 1, 0},
        '{10, 0, 3, 0, 1,  5, -1, -1, 10, 3, 1, 0},
        '{10, 0, 3, 0, 1,  9, -1,  3, 14, 3, 1, 0},
        '{10, 0, 3, 0, 0,  2, -1, -1, 10, 3, 0, 0},
        '{10, 0, 3, 0, 1,  1,  3, -1, 10, 3, 1, 0},
        '{10, 0, 3, 0, 1,  1,  5, -1, 10, 3, 2, 0},
        '{ 5, 0, 7, 0, 1,  0, -1,  2,  9, 7, 1, 1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_reset();
        attack_req  = 1'b0;
        recover_req = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int un = 0, sn = 0, fn = 0, dn = 0, inn = 0, stage = 0;
        bit ord = 1'b1;
        upd_len        = 16'(v.upd);
        luri_len       = 16'(v.luri);
        settle_len     = 16'(v.set);
        fast_recov_en  = v.frec[0];
        fast_attack_en = v.fatt[0];
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if (stage == 0) begin
                if (phase == 2'd0) un++;
                else if (phase == 2'd1) begin stage = 1; sn++; end
                else ord = 1'b0;
            end else if (stage == 1) begin
                if (phase == 2'd1) sn++;
                else if (phase == 2'd2) begin stage = 2; fn++; end
                else ord = 1'b0;
            end else begin
                if (phase == 2'd2) fn++;
                else if (phase == 2'd0) stage = 3;
                else ord = 1'b0;
            end
            if (stage == 3 || !ord) break;
            dn  += int'(gain_dec);
            inn += int'(gain_inc);
            attack_req  = (i == v.a) || (i == v.a2);
            recover_req = (i == v.r);
            @(negedge clk);
        end
        attack_req  = 1'b0;
        recover_req = 1'b0;
        chk(ord && stage == 3, "R1 phase order", stage, 3);
        chk(un == v.eupd, "R3/R4/R7 interval length", un, v.eupd);
        chk(sn == v.eset, "R3 settling length", sn, v.eset);
        chk(fn == 5, "R2 fixed delay length", fn, 5);
        chk(dn == v.edec, "R5/R6 decrement count", dn, v.edec);
        chk(inn == v.einc, "R8/R9 increment count", inn, v.einc);
    endtask

    initial begin
        int n;
        int dn;
        int inn;
        // R10: state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(phase == 2'd0, "R10 reset phase", int'(phase), 0);
        chk(gain_dec == 1'b0, "R10 reset gain_dec", int'(gain_dec), 0);
        chk(gain_inc == 1'b0, "R10 reset gain_inc", int'(gain_inc), 0);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k]);
        end

        // R3: length change mid-interval takes effect only at next entry
        upd_len = 16'd10; settle_len = 16'd3;
        fast_recov_en = 1'b0; fast_attack_en = 1'b1;
        do_reset();
        n = 0;
        while (phase == 2'd0 && n < 100) begin
            n++;
            if (n == 2) upd_len = 16'd2;
            @(negedge clk);
        end
        chk(n == 10, "R3 length sampled at entry", n, 10);
        while (phase != 2'd0) @(negedge clk);
        n = 0;
        while (phase == 2'd0 && n < 100) begin n++; @(negedge clk); end
        chk(n == 2, "R3 new length at next interval", n, 2);

        // R5/R8: requests outside the interval are ignored
        upd_len = 16'd4;
        do_reset();
        while (phase != 2'd1) @(negedge clk);
        dn = 0; inn = 0;
        while (phase != 2'd0) begin
            attack_req = 1'b1; recover_req = 1'b1;
            dn += int'(gain_dec);
            @(negedge clk);
        end
        attack_req = 1'b0; recover_req = 1'b0;
        while (phase == 2'd0) begin
            dn += int'(gain_dec); inn += int'(gain_inc);
            @(negedge clk);
        end
        inn += int'(gain_inc);
        chk(dn == 0, "R5 attack outside interval ignored", dn, 0);
        chk(inn == 0, "R8 recovery outside interval ignored", inn, 0);

        // R10: reset during hold-off clears the hold-off counter
        upd_len = 16'd20; settle_len = 16'd8;
        do_reset();
        attack_req = 1'b1;
        @(negedge clk);
        attack_req = 1'b0;
        chk(gain_dec == 1'b1, "R5 first attack strobe", int'(gain_dec), 1);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(phase == 2'd0, "R10 phase after mid reset", int'(phase), 0);
        rst = 1'b0;
        attack_req = 1'b1;
        @(negedge clk);
        attack_req = 1'b0;
        chk(gain_dec == 1'b1, "R10 hold-off cleared by reset", int'(gain_dec), 1);
        @(negedge clk);
        chk(gain_dec == 1'b0, "R5 strobe lasts one cycle", int'(gain_dec), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule